// File: doc/BRIEF.md
# Paired-page TLB lookup unit

This block is a fully associative translation lookaside buffer for a 32-bit virtual address space. Each of its entries maps a pair of adjacent virtual pages to two physical frames: an even page and an odd page. Each entry carries its own variable page size, from 4 KiB upward. A lookup takes a virtual address, a read/write flag and the current 8-bit address-space identifier. In the same cycle it returns a physical address and a two-bit result code.

An entry hits when two conditions hold. First, its tag bits (the bits above the entry's page-pair mask) equal the same bits of the address. Second, it is marked global or its stored identifier equals the current one. The half-page select bit then chooses the frame number, valid bit and dirty bit of the even or odd page. An invalid half, or a write to a clean half, yields its own result code. This lets the surrounding pipeline raise the right exception.

Entries are loaded one at a time through a write port that takes an index. Replacement choice and refill sequencing are left to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: A synchronous active-high reset clears every field of every entry to zero. Afterwards, an address whose bits 31:13 are zero, looked up with identifier 0, reports invalid (code 2). Any other address reports no match (code 1).
- R2: An entry hits only when both hold: (a) its global flag is set or its stored identifier equals `lk_asid`; (b) `lk_vaddr[31:13]` equals its stored VPN2 on every bit position not covered by its page mask.
- R3: When the selected half of a hitting entry has its valid bit clear, the result is invalid (code 2), for reads and writes alike.
- R4: A read, or a write to a half whose dirty bit is set, gives match (code 0). The physical address is then the selected frame number shifted left by 12, ORed with the address bits below the select bit.
- R5: A write to a valid half whose dirty bit is clear gives modified (code 3). A read never gives code 3.
- R6: When no entry hits, the result is no match (code 1). For every result other than match, `pa` is zero.
- R7: Page mask bit j widens the page pair to cover address bit 13+j. The mask must be contiguous ones from bit 0. With k mask bits set, address bit 12+k selects the odd half when 1 and the even half when 0.
- R8: When several entries hit, the one with the lowest index decides the result and the physical address.
- R9: A lookup is combinational from its inputs in the same cycle. A write through the port changes lookups only from the clock edge on which `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| lk_asid | input | 8 | Current address-space identifier |
| pa | output | 32 | Translated physical address, zero unless result is match |
| result | output | 2 | 0 match, 1 no match, 2 invalid, 3 modified |
| wr_en | input | 1 | Load one entry on this clock edge |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn2 | input | 19 | Virtual page-pair number (address bits 31:13) |
| wr_asid | input | 8 | Identifier stored with the entry |
| wr_global | input | 1 | Entry matches every identifier |
| wr_pmask | input | 12 | Page-pair size mask, contiguous ones from bit 0 |
| wr_pfn_even | input | 20 | Frame number for the even half |
| wr_valid_even | input | 1 | Even half valid |
| wr_dirty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Frame number for the odd half |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_dirty_odd | input | 1 | Odd half writable |

## Verification
Lookup results are due zero cycles after the address, flag and identifier settle. Entry loads become visible one edge after `wr_en`. The bench therefore drives inputs just after a rising edge and compares `pa` and `result` against a behavioural model at the following falling edge. The model's table is updated at the same rising edge where the design stores the entry. A write issued together with a lookup of the same page is checked twice: at the falling edge before the store, where the old mapping must still show, and one cycle later, where the new mapping must show.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int ASID_W = 8;
    localparam int PG_SH  = 12;
    localparam int PM_W   = 12;
    localparam int VPN2_W = VA_W - PG_SH - 1;
    localparam int PFN_W  = PA_W - PG_SH;

    typedef enum logic [1:0] {
        RES_MATCH    = 2'd0,
        RES_NOMATCH  = 2'd1,
        RES_INVALID  = 2'd2,
        RES_MODIFIED = 2'd3
    } tlb_res_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             valid;
        logic             dirty;
    } tlb_half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              global_en;
        logic [PM_W-1:0]   pmask;
        tlb_half_t         even;
        tlb_half_t         odd;
    } tlb_entry_t;

    // Offset mask of one half page: all bits below the even/odd select bit.
    function automatic logic [VA_W-1:0] half_mask(input logic [PM_W-1:0] pm);
        logic [VA_W-1:0] pair;
        pair = VA_W'({pm, {(PG_SH + 1){1'b1}}});
        return pair >> 1;
    endfunction

endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
(
    input  tlb_entry_t              ent,
    input  logic [VA_W-1:0]         vaddr,
    input  logic [ASID_W-1:0]       asid,
    output logic                    hit,
    output logic                    odd,
    output logic [VA_W-1:0]         offs_mask
);
    logic [VA_W-1:0]   pair_mask;
    logic [VPN2_W-1:0] tag_care;
    logic              id_ok;
    logic              tag_ok;

    always_comb begin
        offs_mask = half_mask(ent.pmask);
        pair_mask = {offs_mask[VA_W-2:0], 1'b1};
        tag_care  = ~VPN2_W'(ent.pmask);
        id_ok     = ent.global_en || (ent.asid == asid);
        tag_ok    = ((vaddr[VA_W-1:PG_SH+1] ^ ent.vpn2) & tag_care) == '0;
        hit       = id_ok && tag_ok;
        odd       = |(vaddr & pair_mask & ~offs_mask);
    end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
        found = |hits;
    end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VA_W-1:0]      lk_vaddr,
    input  logic                 lk_write,
    input  logic [ASID_W-1:0]    lk_asid,
    output logic [PA_W-1:0]      pa,
    output logic [1:0]           result,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [VPN2_W-1:0]    wr_vpn2,
    input  logic [ASID_W-1:0]    wr_asid,
    input  logic                 wr_global,
    input  logic [PM_W-1:0]      wr_pmask,
    input  logic [PFN_W-1:0]     wr_pfn_even,
    input  logic                 wr_valid_even,
    input  logic                 wr_dirty_even,
    input  logic [PFN_W-1:0]     wr_pfn_odd,
    input  logic                 wr_valid_odd,
    input  logic                 wr_dirty_odd
);
    tlb_entry_t [N_ENT-1:0] tbl;
    tlb_entry_t             new_ent;

    logic [N_ENT-1:0]       way_hit;
    logic [N_ENT-1:0]       way_odd;
    logic [VA_W-1:0]        way_offs [N_ENT];

    logic                   found;
    logic [IDX_W-1:0]       sel;
    tlb_half_t              half;
    tlb_res_e               res;

    always_comb begin
        new_ent.vpn2       = wr_vpn2;
        new_ent.asid       = wr_asid;
        new_ent.global_en  = wr_global;
        new_ent.pmask      = wr_pmask;
        new_ent.even.pfn   = wr_pfn_even;
        new_ent.even.valid = wr_valid_even;
        new_ent.even.dirty = wr_dirty_even;
        new_ent.odd.pfn    = wr_pfn_odd;
        new_ent.odd.valid  = wr_valid_odd;
        new_ent.odd.dirty  = wr_dirty_odd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= new_ent;
        end
    end

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_way
            tlb_way_match u_match (
                .ent       (tbl[g]),
                .vaddr     (lk_vaddr),
                .asid      (lk_asid),
                .hit       (way_hit[g]),
                .odd       (way_odd[g]),
                .offs_mask (way_offs[g])
            );
        end
    endgenerate

    tlb_prio_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
        .hits  (way_hit),
        .found (found),
        .idx   (sel)
    );

    always_comb begin
        half = way_odd[sel] ? tbl[sel].odd : tbl[sel].even;
        res  = RES_NOMATCH;
        pa   = '0;
        if (found) begin
            if (!half.valid) begin
                res = RES_INVALID;
            end else if (lk_write && !half.dirty) begin
                res = RES_MODIFIED;
            end else begin
                res = RES_MATCH;
                pa  = {half.pfn, {PG_SH{1'b0}}} | PA_W'(lk_vaddr & way_offs[sel]);
            end
        end
        result = res;
    end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
    import tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [VA_W-1:0]        lk_vaddr,
    input logic                   lk_write,
    input logic [PA_W-1:0]        pa,
    input logic [1:0]             result,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_idx,
    input tlb_entry_t             new_ent,
    input tlb_entry_t [N_ENT-1:0] tbl
);
    logic             pend;
    logic [IDX_W-1:0] idx_q;
    tlb_entry_t       ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            idx_q <= '0;
            ent_q <= '0;
        end else begin
            pend  <= wr_en;
            idx_q <= wr_idx;
            ent_q <= new_ent;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tbl == '0));

    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        pend |-> (tbl[idx_q] == ent_q));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (result == 2'd0) |-> (pa[PG_SH-1:0] == lk_vaddr[PG_SH-1:0]));

    a_r6_pa_zero_on_miss: assert property (@(posedge clk) disable iff (rst)
        (result != 2'd0) |-> (pa == '0));

    a_r5_read_not_modified: assert property (@(posedge clk) disable iff (rst)
        !lk_write |-> (result != 2'd3));
endmodule

bind tlb_lookup tlb_lookup_chk #(.N_ENT(N_ENT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_vaddr (lk_vaddr),
    .lk_write (lk_write),
    .pa       (pa),
    .result   (result),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .new_ent  (new_ent),
    .tbl      (tbl)
);

// File: tb/tlb_lookup_test.sv
`timescale 1ns/1ps
module tlb_lookup_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] lk_vaddr = 0;
    logic        lk_write = 0;
    logic [7:0]  lk_asid = 0;
    logic [31:0] pa;
    logic [1:0]  result;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [18:0] wr_vpn2 = 0;
    logic [7:0]  wr_asid = 0;
    logic        wr_global = 0;
    logic [11:0] wr_pmask = 0;
    logic [19:0] wr_pfn_even = 0, wr_pfn_odd = 0;
    logic        wr_valid_even = 0, wr_dirty_even = 0, wr_valid_odd = 0, wr_dirty_odd = 0;

    int checks = 0;
    int failures = 0;
    bit running = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference table
    logic [18:0] m_vpn [16];
    logic [7:0]  m_asid [16];
    bit          m_g [16];
    logic [11:0] m_pm [16];
    logic [19:0] m_pfn0 [16], m_pfn1 [16];
    bit          m_v0 [16], m_d0 [16], m_v1 [16], m_d1 [16];

    always #4 clk = ~clk;

    tlb_lookup uut (
        .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_asid(lk_asid),
        .pa(pa), .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
        .wr_asid(wr_asid), .wr_global(wr_global), .wr_pmask(wr_pmask),
        .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd)
    );

    always @(posedge clk) begin
        for (int i = 0; i < 16; i++) begin
            if (rst || (wr_en && wr_idx == 4'(i))) begin
                m_vpn[i]  <= rst ? 19'd0 : wr_vpn2;
                m_asid[i] <= rst ? 8'd0 : wr_asid;
                m_g[i]    <= rst ? 1'b0 : wr_global;
                m_pm[i]   <= rst ? 12'd0 : wr_pmask;
                m_pfn0[i] <= rst ? 20'd0 : wr_pfn_even;
                m_v0[i]   <= rst ? 1'b0 : wr_valid_even;
                m_d0[i]   <= rst ? 1'b0 : wr_dirty_even;
                m_pfn1[i] <= rst ? 20'd0 : wr_pfn_odd;
                m_v1[i]   <= rst ? 1'b0 : wr_valid_odd;
                m_d1[i]   <= rst ? 1'b0 : wr_dirty_odd;
            end
        end
    end

    function automatic void model_look(input logic [31:0] va, input bit wr, input logic [7:0] asid,
                                       output int res, output logic [31:0] exp_pa);
        res = 1;
        exp_pa = 0;
        for (int i = 0; i < 16; i++) begin
            int k;
            logic [18:0] care;
            bit odd, v, d;
            logic [19:0] pfn;
            logic [31:0] below;
            k = 0;
            for (int b = 0; b < 12; b++) if (m_pm[i][b]) k++;
            care = ~{7'd0, m_pm[i]};
            if ((m_g[i] || m_asid[i] == asid) && (((va >> 13) ^ 32'(m_vpn[i])) & 32'(care)) == 0) begin
                odd = va[12 + k];
                v = odd ? m_v1[i] : m_v0[i];
                d = odd ? m_d1[i] : m_d0[i];
                pfn = odd ? m_pfn1[i] : m_pfn0[i];
                below = (32'd1 << (12 + k)) - 32'd1;
                if (!v) res = 2;
                else if (wr && !d) res = 3;
                else begin
                    res = 0;
                    exp_pa = {pfn, 12'd0} | (va & below);
                end
                break;
            end
        end
    endfunction

    // reference comparison on every clock
    always @(negedge clk) begin
        int er;
        logic [31:0] ep;
        if (running && !rst) begin
            model_look(lk_vaddr, lk_write, lk_asid, er, ep);
            checks++;
            if (int'(result) != er || pa !== ep) begin
                failures++;
                $display("FAIL %s model: result=%0d pa=%08h expected result=%0d pa=%08h",
                         cur_req, result, pa, er, ep);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic look(input logic [31:0] va, input bit wr, input logic [7:0] asid, input string req);
        cur_req = req;
        lk_vaddr = va;
        lk_write = wr;
        lk_asid = asid;
    endtask

    // literal check at the falling edge of the current cycle
    task automatic expect_now(input int er, input logic [31:0] ep, input string req);
        @(negedge clk);
        checks++;
        if (int'(result) != er || pa !== ep) begin
            failures++;
            $display("FAIL %s literal: result=%0d pa=%08h expected result=%0d pa=%08h",
                     req, result, pa, er, ep);
        end
        step();
    endtask

    task automatic load(input int idx, input logic [18:0] vpn, input logic [7:0] asid, input bit g,
                        input logic [11:0] pm, input logic [19:0] p0, input bit v0, input bit d0,
                        input logic [19:0] p1, input bit v1, input bit d1);
        wr_en = 1; wr_idx = 4'(idx); wr_vpn2 = vpn; wr_asid = asid; wr_global = g; wr_pmask = pm;
        wr_pfn_even = p0; wr_valid_even = v0; wr_dirty_even = d0;
        wr_pfn_odd = p1; wr_valid_odd = v1; wr_dirty_odd = d1;
        step();
        wr_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 0;
        running = 1;
        // R1: cleared table
        look(32'h0000_0ABC, 0, 8'd0, "R1"); expect_now(2, 0, "R1");
        look(32'h0000_1ABC, 1, 8'd0, "R1"); expect_now(2, 0, "R1");
        look(32'h8000_0000, 0, 8'd0, "R1"); expect_now(1, 0, "R1");

        load(3, 19'h200, 8'd5, 0, 12'h000, 20'h11111, 1, 1, 20'h22222, 1, 0);
        look(32'h0040_0123, 0, 8'd5, "R4"); expect_now(0, 32'h1111_1123, "R4");
        look(32'h0040_1456, 0, 8'd5, "R7"); expect_now(0, 32'h2222_2456, "R7");
        look(32'h0040_1456, 1, 8'd5, "R5"); expect_now(3, 0, "R5");
        look(32'h0040_0123, 1, 8'd5, "R4"); expect_now(0, 32'h1111_1123, "R4");
        look(32'h0040_0123, 0, 8'd6, "R2"); expect_now(1, 0, "R2");
        look(32'h0040_2000, 0, 8'd5, "R6"); expect_now(1, 0, "R6");

        load(5, 19'h8000, 8'd9, 1, 12'h003, 20'h30000, 1, 1, 20'h40000, 0, 1);
        look(32'h1000_3ABC, 0, 8'd0, "R7"); expect_now(0, 32'h3000_3ABC, "R7");
        look(32'h1000_4ABC, 0, 8'd0, "R3"); expect_now(2, 0, "R3");
        look(32'h1000_7FFC, 1, 8'd1, "R3"); expect_now(2, 0, "R3");
        look(32'h1000_8000, 0, 8'd0, "R7"); expect_now(1, 0, "R7");

        load(12, 19'h300, 8'd0, 1, 12'h000, 20'h66666, 1, 1, 20'h0, 0, 0);
        load(9, 19'h300, 8'd5, 0, 12'h000, 20'h55555, 1, 1, 20'h0, 0, 0);
        look(32'h0060_0010, 0, 8'd5, "R8"); expect_now(0, 32'h5555_5010, "R8");
        // R9: rewrite entry 9 while looking up: old mapping until the edge
        cur_req = "R9";
        wr_en = 1; wr_idx = 4'd9; wr_asid = 8'd7;
        expect_now(0, 32'h5555_5010, "R9");
        wr_en = 0;
        expect_now(0, 32'h6666_6010, "R9");

        // mixed random loads and lookups against the model
        for (int n = 0; n < 3000; n++) begin
            logic [18:0] vpn;
            vpn = 19'h200 + 19'($urandom % 6);
            if ($urandom % 4 == 0) begin
                wr_en = 1; wr_idx = 4'($urandom); wr_vpn2 = vpn; wr_asid = 8'($urandom % 3);
                wr_global = ($urandom % 5 == 0); wr_pmask = 12'((1 << ($urandom % 4)) - 1);
                wr_pfn_even = 20'($urandom); wr_valid_even = 1'($urandom); wr_dirty_even = 1'($urandom);
                wr_pfn_odd = 20'($urandom); wr_valid_odd = 1'($urandom); wr_dirty_odd = 1'($urandom);
            end else begin
                wr_en = 0;
            end
            look({vpn, 13'($urandom)}, 1'($urandom), 8'($urandom % 3), "R2");
            step();
        end
        wr_en = 0;
        step();
        finish_run();
    end
endmodule